// File: doc/BRIEF.md
# Integer Issue Interlock Controller

This block sits at the issue stage of a single-issue integer pipeline and decides, every cycle, whether the instruction on offer may leave. Each instruction arrives as a 4-bit class code, a flag that says whether it reads the result of the most recently issued instruction, and a valid strobe. The controller raises `issue_ok` only when the instruction is valid and no hazard stands in its way. The instruction is held at the inputs until it is accepted.

Three hazards are tracked. The first is structural: a separate multiply/divide unit stays busy for a number of cycles that depends on the class. The second is a data hazard against the last issued producer, with its own delay for each producer class. Register jumps and calls have their own delay rules on top of this. The third is the readiness of the HI/LO result pair, which reads of HI/LO must wait for. A saturating counter of stalled cycles is brought out for observation.

Class codes: 0 ALU (arithmetic, logic, shift, set-less-than, move, branch), 1 load, 2 store or prefetch, 3 register jump or call, 4 32-bit multiply or multiply-accumulate, 5 64-bit multiply, 6 three-operand 32-bit multiply, 7 32-bit divide, 8 64-bit divide, 9 move to HI/LO, 10 move from HI/LO, 11 serializing (unknown, multi-instruction, atomic, sync loop). Codes 12 to 15 are handled as ALU.

Top module: `int_issue_ctl`

## Requirements
- R1: A synchronous active-high reset clears all busy, readiness and stall state. Right after reset, any class issues in its first valid cycle, even with the dependency flag set, and the stall count reads 0.
- R2: `issue_ok` is low whenever `in_valid` is low. A cycle with `in_valid` low is not counted as a stall.
- R3: With the dependency flag set, a consumer that is not a register jump issues N cycles after its producer. N is 1 for ALU, store, move-to-HI/LO and serializing producers, 2 for load, 32-bit multiply and move-from-HI/LO, 4 for three-operand multiply, and 9 for 64-bit multiply.
- R4: With the dependency flag clear and no structural hazard, the next instruction issues in the cycle right after its predecessor, whatever the producer's latency.
- R5: An instruction that uses the multiply/divide unit (codes 4 to 11) waits until the unit is free. The unit is held 2 cycles by codes 4, 5 and 6, `DIV32_OCC` (34) cycles by code 7, `DIV64_OCC` (66) cycles by code 8, and 1 cycle by codes 9, 10 and 11.
- R6: A dependent consumer of a 32-bit divide issues 34 cycles after it, and of a 64-bit divide 66 cycles after it.
- R7: A register jump (code 3) with the dependency flag set issues 2 cycles after an ALU producer, and 3 cycles after a load, a move-from-HI/LO or a three-operand multiply. Without the flag it issues 1 cycle after any producer.
- R8: Any instruction that follows a register jump issues no sooner than 2 cycles after the jump (one bubble), with or without the dependency flag.
- R9: A move-from-HI/LO (code 10) waits until the last HI/LO writer's result is ready, with or without the dependency flag. The writers are codes 4, 5, 7, 8 and 9. The 64-bit multiply needs 9 cycles, the divides 34 or 66, and a 32-bit multiply 2.
- R10: `stall_count` rises by one for each cycle in which `in_valid` is high and `issue_ok` is low, and holds at its all-ones value once it gets there.
- R11: Class codes 12 to 15 behave exactly like code 0: a latency of 1 and no use of the multiply/divide unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_class | input | 4 | Class code of the offered instruction |
| in_dep | input | 1 | Offered instruction reads the last issued instruction's result |
| issue_ok | output | 1 | Offered instruction issues at the coming clock edge |
| stall_count | output | STALL_W | Saturating count of stalled valid cycles |

## Verification
The bench measures the gap in cycles between a producer's issue and its consumer's issue for every producer class and for the jump cases. A counter loaded with the full latency instead of latency minus one would show up at once as a gap one cycle too long. The jump overrides are probed in both directions: load to jump must grow to 3 while three-operand multiply to jump must shrink from 4 to 3, so a design that ignored the override would fail in one of them. The 64-bit multiply followed by a move from HI/LO separates unit occupancy (2 cycles) from HI/LO readiness (9 cycles), which catches a design that keys on only one of them. Reset in the middle of a long divide, the one-bubble rule after a jump without a dependency, and stall-count saturation cover the remaining cases.

// File: rtl/iic_pkg.sv
package iic_pkg;

  typedef enum logic [3:0] {
    K_ALU    = 4'd0,
    K_LOAD   = 4'd1,
    K_STORE  = 4'd2,
    K_JUMP   = 4'd3,
    K_MUL32  = 4'd4,
    K_MUL64  = 4'd5,
    K_MUL3   = 4'd6,
    K_DIV32  = 4'd7,
    K_DIV64  = 4'd8,
    K_MTHILO = 4'd9,
    K_MFHILO = 4'd10,
    K_SERIAL = 4'd11
  } iclass_e;

  localparam int LAT_LOAD   = 2;
  localparam int LAT_MUL32  = 2;
  localparam int LAT_MUL64  = 9;
  localparam int LAT_MUL3   = 4;
  localparam int LAT_MFHILO = 2;
  localparam int LAT_JUMP   = 2;
  localparam int MUL_OCC    = 2;
  localparam int JR_FAST    = 2;
  localparam int JR_SLOW    = 3;

  // Codes beyond the defined set fold onto the plain ALU class (R11).
  function automatic iclass_e to_class(input logic [3:0] code);
    if (code > 4'd11) return K_ALU;
    return iclass_e'(code);
  endfunction

  // Result latency of a producer towards a dependent consumer.
  function automatic int result_lat(input iclass_e c, input int d32, input int d64);
    case (c)
      K_LOAD:   return LAT_LOAD;
      K_JUMP:   return LAT_JUMP;
      K_MUL32:  return LAT_MUL32;
      K_MUL64:  return LAT_MUL64;
      K_MUL3:   return LAT_MUL3;
      K_DIV32:  return d32;
      K_DIV64:  return d64;
      K_MFHILO: return LAT_MFHILO;
      default:  return 1;
    endcase
  endfunction

  // Cycles the multiply/divide unit is held; 0 means the class never uses it.
  function automatic int mdu_occ(input iclass_e c, input int d32, input int d64);
    case (c)
      K_MUL32, K_MUL64, K_MUL3:     return MUL_OCC;
      K_DIV32:                      return d32;
      K_DIV64:                      return d64;
      K_MTHILO, K_MFHILO, K_SERIAL: return 1;
      default:                      return 0;
    endcase
  endfunction

  function automatic logic writes_hilo(input iclass_e c);
    return (c == K_MUL32) || (c == K_MUL64) || (c == K_DIV32) ||
           (c == K_DIV64) || (c == K_MTHILO);
  endfunction

  function automatic logic reads_hilo(input iclass_e c);
    return c == K_MFHILO;
  endfunction

  // Minimum distance from the last producer's issue to this consumer's issue.
  function automatic int required_gap(input iclass_e last, input iclass_e cons,
                                      input int d32, input int d64);
    if (last == K_JUMP) return LAT_JUMP;
    if (cons == K_JUMP) begin
      case (last)
        K_ALU:                    return JR_FAST;
        K_LOAD, K_MFHILO, K_MUL3: return JR_SLOW;
        default:                  return result_lat(last, d32, d64);
      endcase
    end
    return result_lat(last, d32, d64);
  endfunction

endpackage

// File: rtl/iic_mdu_track.sv
module iic_mdu_track
  import iic_pkg::*;
#(
  parameter int CNT_W     = 7,
  parameter int DIV32_OCC = 34,
  parameter int DIV64_OCC = 66
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  iclass_e          cls,
  output logic [CNT_W-1:0] busy_cnt,
  output logic [CNT_W-1:0] hilo_cnt,
  output logic             mdu_free,
  output logic             hilo_ready
);

  int occ_now;
  int lat_now;

  always_comb begin
    occ_now = mdu_occ(cls, DIV32_OCC, DIV64_OCC);
    lat_now = result_lat(cls, DIV32_OCC, DIV64_OCC);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cnt <= '0;
      hilo_cnt <= '0;
    end else begin
      if (issue && occ_now != 0)
        busy_cnt <= CNT_W'(occ_now - 1);
      else if (busy_cnt != '0)
        busy_cnt <= busy_cnt - 1'b1;

      if (issue && writes_hilo(cls))
        hilo_cnt <= CNT_W'(lat_now - 1);
      else if (hilo_cnt != '0)
        hilo_cnt <= hilo_cnt - 1'b1;
    end
  end

  assign mdu_free   = (busy_cnt == '0);
  assign hilo_ready = (hilo_cnt == '0);

  // R5: without a new issue the occupancy can only drain.
  p_busy_drain_r5: assert property (@(posedge clk) disable iff (rst)
    !issue |=> busy_cnt <= $past(busy_cnt));

  // R9: without a new issue the HI/LO wait can only drain.
  p_hilo_drain_r9: assert property (@(posedge clk) disable iff (rst)
    !issue |=> hilo_cnt <= $past(hilo_cnt));

endmodule

// File: rtl/iic_dep_track.sv
module iic_dep_track
  import iic_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  iclass_e          cls,
  output logic [CNT_W-1:0] age,
  output iclass_e          last_cls
);

  localparam logic [CNT_W-1:0] AGE_MAX = '1;

  // age counts cycles since the last issue and sits at AGE_MAX when idle.
  always_ff @(posedge clk) begin
    if (rst) begin
      age      <= AGE_MAX;
      last_cls <= K_ALU;
    end else if (issue) begin
      age      <= CNT_W'(1);
      last_cls <= cls;
    end else if (age != AGE_MAX) begin
      age <= age + 1'b1;
    end
  end

  // R3: the cycle after an issue is distance one from that producer.
  p_age_restart_r3: assert property (@(posedge clk) disable iff (rst)
    issue |=> age == CNT_W'(1));

  p_age_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    age != '0);

endmodule

// File: rtl/iic_stall_ctr.sv
module iic_stall_ctr #(
  parameter int STALL_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stall,
  output logic [STALL_W-1:0] cnt
);

  localparam logic [STALL_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (stall && cnt != CNT_MAX)
      cnt <= cnt + 1'b1;
  end

  // R10: one step per stalled cycle below the ceiling.
  p_stall_step_r10: assert property (@(posedge clk) disable iff (rst)
    (stall && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);

  // R10: the ceiling holds.
  p_stall_sat_r10: assert property (@(posedge clk) disable iff (rst)
    cnt == CNT_MAX |=> cnt == CNT_MAX);

  // R2: no count without a stall.
  p_stall_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !stall |=> $stable(cnt));

endmodule

// File: rtl/int_issue_ctl.sv
module int_issue_ctl
  import iic_pkg::*;
#(
  parameter int DIV32_OCC = 34,
  parameter int DIV64_OCC = 66,
  parameter int STALL_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [3:0]         in_class,
  input  logic               in_dep,
  output logic               issue_ok,
  output logic [STALL_W-1:0] stall_count
);

  localparam int CNT_W = $clog2(DIV64_OCC + 2);

  iclass_e          cur_cls;
  iclass_e          last_cls;
  logic [CNT_W-1:0] age;
  logic [CNT_W-1:0] busy_cnt;
  logic [CNT_W-1:0] hilo_cnt;
  logic             mdu_free;
  logic             hilo_ready;
  logic             needs_mdu;
  logic             mdu_block;
  logic             hilo_block;
  logic             dep_block;
  logic             stall_evt;
  int               gap_req;

  assign cur_cls = to_class(in_class);

  always_comb begin
    gap_req    = required_gap(last_cls, cur_cls, DIV32_OCC, DIV64_OCC);
    needs_mdu  = mdu_occ(cur_cls, DIV32_OCC, DIV64_OCC) != 0;
    mdu_block  = needs_mdu && !mdu_free;
    hilo_block = reads_hilo(cur_cls) && !hilo_ready;
    dep_block  = (in_dep || last_cls == K_JUMP) && (32'(age) < 32'(gap_req));
  end

  assign issue_ok  = in_valid && !mdu_block && !hilo_block && !dep_block;
  assign stall_evt = in_valid && !issue_ok;

  iic_mdu_track #(
    .CNT_W     (CNT_W),
    .DIV32_OCC (DIV32_OCC),
    .DIV64_OCC (DIV64_OCC)
  ) u_mdu (
    .clk        (clk),
    .rst        (rst),
    .issue      (issue_ok),
    .cls        (cur_cls),
    .busy_cnt   (busy_cnt),
    .hilo_cnt   (hilo_cnt),
    .mdu_free   (mdu_free),
    .hilo_ready (hilo_ready)
  );

  iic_dep_track #(
    .CNT_W (CNT_W)
  ) u_dep (
    .clk      (clk),
    .rst      (rst),
    .issue    (issue_ok),
    .cls      (cur_cls),
    .age      (age),
    .last_cls (last_cls)
  );

  iic_stall_ctr #(
    .STALL_W (STALL_W)
  ) u_stall (
    .clk   (clk),
    .rst   (rst),
    .stall (stall_evt),
    .cnt   (stall_count)
  );

  p_no_issue_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> !issue_ok);

  p_mdu_free_on_issue_r5: assert property (@(posedge clk) disable iff (rst)
    (issue_ok && needs_mdu) |-> busy_cnt == '0);

  // R6: a 32-bit divide holds the unit for its full occupancy.
  p_div32_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (issue_ok && cur_cls == K_DIV32) |=> busy_cnt == CNT_W'(DIV32_OCC - 1));

  p_div64_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (issue_ok && cur_cls == K_DIV64) |=> busy_cnt == CNT_W'(DIV64_OCC - 1));

  p_hilo_ready_r9: assert property (@(posedge clk) disable iff (rst)
    (issue_ok && cur_cls == K_MFHILO) |-> hilo_cnt == '0);

  // R8: one bubble after any register jump.
  p_jump_bubble_r8: assert property (@(posedge clk) disable iff (rst)
    (issue_ok && last_cls == K_JUMP) |-> age >= CNT_W'(2));

  // R7: a dependent jump after a load never issues at distance two or less.
  p_jr_load_r7: assert property (@(posedge clk) disable iff (rst)
    (issue_ok && in_dep && cur_cls == K_JUMP && last_cls == K_LOAD) |-> age >= CNT_W'(3));

  // R4: an independent ALU-class instruction is never held by the last producer.
  p_nodep_free_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_dep && cur_cls == K_ALU && last_cls != K_JUMP) |-> issue_ok);

endmodule

// File: tb/tb_int_issue_ctl.sv
module tb_int_issue_ctl;

  localparam int SW = 6;

  localparam int C_ALU = 0, C_LOAD = 1, C_STORE = 2, C_JUMP = 3, C_MUL32 = 4,
                 C_MUL64 = 5, C_MUL3 = 6, C_DIV32 = 7, C_DIV64 = 8,
                 C_MTHI = 9, C_MFHI = 10, C_SER = 11;

  localparam int NV = 29;
  // producer, consumer, dependency flag, expected issue distance
  localparam int VEC [NV][4] = '{
    '{C_ALU,   C_ALU,   1, 1},   // R3
    '{C_LOAD,  C_ALU,   1, 2},   // R3
    '{C_LOAD,  C_ALU,   0, 1},   // R4
    '{C_STORE, C_ALU,   1, 1},   // R3
    '{C_MUL32, C_ALU,   1, 2},   // R3
    '{C_MUL64, C_ALU,   1, 9},   // R3
    '{C_MUL3,  C_ALU,   1, 4},   // R3
    '{C_MFHI,  C_ALU,   1, 2},   // R3
    '{C_MTHI,  C_MFHI,  1, 1},   // R3
    '{C_DIV32, C_ALU,   1, 34},  // R6
    '{C_DIV64, C_ALU,   1, 66},  // R6
    '{C_DIV32, C_MUL32, 0, 34},  // R5
    '{C_DIV64, C_MTHI,  0, 66},  // R5
    '{C_MUL32, C_MUL32, 0, 2},   // R5
    '{C_MUL3,  C_MUL32, 0, 2},   // R5
    '{C_MTHI,  C_MTHI,  0, 1},   // R5
    '{C_SER,   C_SER,   0, 1},   // R5
    '{C_ALU,   C_JUMP,  1, 2},   // R7
    '{C_ALU,   C_JUMP,  0, 1},   // R7
    '{C_LOAD,  C_JUMP,  1, 3},   // R7
    '{C_MFHI,  C_JUMP,  1, 3},   // R7
    '{C_MUL3,  C_JUMP,  1, 3},   // R7
    '{C_JUMP,  C_ALU,   0, 2},   // R8
    '{C_JUMP,  C_ALU,   1, 2},   // R8
    '{C_MUL64, C_MFHI,  0, 9},   // R9
    '{C_DIV32, C_MFHI,  0, 34},  // R9
    '{C_MUL64, C_MUL32, 0, 2},   // R9 (not a HI/LO reader)
    '{15,      C_ALU,   1, 1},   // R11
    '{C_ALU,   C_DIV32, 0, 1}    // R4
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [3:0]    in_class = 4'd0;
  logic          in_dep = 1'b0;
  logic          issue_ok;
  logic [SW-1:0] stall_count;

  int n_checks = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  int_issue_ctl #(.STALL_W(SW)) dut (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_class    (in_class),
    .in_dep      (in_dep),
    .issue_ok    (issue_ok),
    .stall_count (stall_count)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Issue p from a quiet state, then offer c and count cycles until it issues.
  task automatic run_pair(input int p, input int c, input int d, output int gap);
    @(negedge clk);
    in_valid = 1'b1; in_class = 4'(p); in_dep = 1'b0;
    #1;
    check(issue_ok == 1'b1, "R4 producer from quiet state", int'(issue_ok), 1);
    gap = 0;
    do begin
      @(negedge clk);
      in_class = 4'(c); in_dep = d[0];
      gap++;
      #1;
    end while (!issue_ok && gap < 200);
    @(negedge clk);
    in_valid = 1'b0; in_dep = 1'b0;
    repeat (70) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    int g;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    // R1 / R2: quiet after reset
    check(issue_ok == 1'b0, "R2 idle after reset", int'(issue_ok), 0);
    check(stall_count == '0, "R1 stall count after reset", int'(stall_count), 0);
    in_class = 4'(C_ALU);
    repeat (3) @(negedge clk);
    #1;
    check(issue_ok == 1'b0, "R2 valid low blocks issue", int'(issue_ok), 0);
    check(stall_count == '0, "R2 valid low not a stall", int'(stall_count), 0);

    for (int i = 0; i < NV; i++) begin
      run_pair(VEC[i][0], VEC[i][1], VEC[i][2], g);
      check(g == VEC[i][3],
            $sformatf("R3-R11 vector %0d (prod %0d cons %0d dep %0d)",
                      i, VEC[i][0], VEC[i][1], VEC[i][2]),
            g, VEC[i][3]);
    end

    // R10: stall counting from a clean state, then saturation
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1;
    check(stall_count == '0, "R1 stall count cleared", int'(stall_count), 0);
    run_pair(C_DIV32, C_ALU, 1, g);
    check(stall_count == SW'(33), "R10 stall count after 32-bit divide", int'(stall_count), 33);
    run_pair(C_DIV64, C_ALU, 1, g);
    check(stall_count == '1, "R10 stall count saturates", int'(stall_count), 63);

    // R1: reset during a long divide releases everything at once
    @(negedge clk);
    in_valid = 1'b1; in_class = 4'(C_DIV64); in_dep = 1'b0;
    @(negedge clk);
    in_class = 4'(C_MUL32); in_dep = 1'b1;
    #1;
    check(issue_ok == 1'b0, "R5 multiply blocked behind divide", int'(issue_ok), 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(issue_ok == 1'b1, "R1 dependent multiply issues after reset", int'(issue_ok), 1);
    check(stall_count == '0, "R1 stall count after mid-run reset", int'(stall_count), 0);
    @(negedge clk);
    in_valid = 1'b0; in_dep = 1'b0;

    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule